// File: doc/BRIEF.md
# Software Write-Protection Command Sequencer

This block sits between the host byte-load stream and the page-load controller of a byte-wide page-write nonvolatile memory. It watches each byte-load event for fixed address/data key patterns. From these it decodes five commands: protected write, unprotect, chip erase, identification entry and identification exit. It keeps one global protection state. It decides which byte loads may reach the page buffer, and it raises a one-cycle erase trigger. In identification mode it supplies the identification bytes to the read path. Array storage and write timing belong to the neighbouring blocks.

The block comes out of reset unprotected, so plain byte loads pass. A three-byte key ending in the write function code arms protection for the whole device. The same key also opens the write permit for one page, and the page-load controller closes that permit with `page_done_i` once the page has been committed. Only the six-byte unprotect key clears protection. A plain load that arrives while the device is protected and no permit is open is dropped. That load also starts a lockout window, and every load during the window is ignored. A key sequence is dropped when a byte breaks it, or when the gap between two of its bytes is longer than the byte-load window.

Top module: `sdp_sequencer`

## Requirements
- R1: After reset, `protected_o`=0, `write_ok_o`=1, `id_mode_o`=0, `lockout_o`=0 and `erase_start_o`=0. A plain load then asserts `data_load_o` in the same cycle.
- R2: The key 5555h/AAh, 2AAAh/55h, 5555h/A0h (address/data) sets `protected_o` and `write_ok_o` from the cycle after its last byte. Key bytes never assert `data_load_o`.
- R3: Once a write key has opened the permit, a `page_done_i` pulse closes it. `write_ok_o` then reads 0 and `protected_o` stays 1. Only the unprotect key clears protection.
- R4: The key 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, 5555h/20h clears `protected_o` and reopens `write_ok_o` from the cycle after its last byte.
- R5: The same six-byte key ending in 5555h/10h pulses `erase_start_o` for exactly one cycle, the cycle after its last byte. It leaves protection unchanged.
- R6: A plain load with `protected_o`=1 and `write_ok_o`=0 does not assert `data_load_o`. It raises `lockout_o` for LOCK_CYC cycles starting the next cycle. Every load arriving while `lockout_o`=1 is ignored, key bytes included.
- R7: The key ending in 5555h/90h sets `id_mode_o`, and the key ending in 5555h/F0h clears it. In identification mode, `id_data_o` is MFR_ID (BFh) for `rd_addr_i`=0, DEV_ID (5Dh) for address 1, and 00h for any other address. Outside that mode it is 00h. Plain loads do not assert `data_load_o` in identification mode.
- R8: A byte that does not match the next key byte abandons the partial key with no change of state. If that byte is 5555h/AAh it starts a new key. Otherwise it is handled as a plain load.
- R9: A key byte that arrives more than WINDOW_CYC cycles after the previous load abandons the partial key. A spacing of exactly WINDOW_CYC cycles is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_valid_i | input | 1 | One byte-load event this cycle |
| load_addr_i | input | ADDR_W | Address of the byte load |
| load_data_i | input | 8 | Data of the byte load |
| page_done_i | input | 1 | Page committed by the write controller; closes the write permit |
| rd_addr_i | input | ADDR_W | Read address for identification data |
| data_load_o | output | 1 | The current load may enter the page buffer |
| write_ok_o | output | 1 | Page writing currently permitted |
| protected_o | output | 1 | Global protection is armed |
| erase_start_o | output | 1 | One-cycle chip-erase trigger |
| lockout_o | output | 1 | Device not accessible after a protected-write attempt |
| id_mode_o | output | 1 | Identification mode active |
| id_data_o | output | 8 | Identification byte for `rd_addr_i` |

## Verification
The bench drives broken keys at every position. It checks that each broken key leaves protection untouched and that a breaking 5555h/AAh restarts a key; a decoder that resets without re-examining the byte would treat that byte as a plain load. Gaps of exactly WINDOW_CYC and WINDOW_CYC+1 cycles are driven to pin the timeout edge, where an off-by-one would accept a stale key or reject a valid one. The bench also loads on the last and first cycles around the lockout window, and it sends key bytes inside the window; a design that checked the lockout one cycle late would let a protected write or a key through. Finally it closes the permit with `page_done_i` and checks that protection survives, catching a design that drops protection together with the permit.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_EXT, ST_K4, ST_K5
  } seq_st_e;

  typedef struct packed {
    logic write_unlock;
    logic unprotect;
    logic erase;
    logic id_enter;
    logic id_exit;
  } sdp_cmd_t;

  localparam logic [7:0] KEY_FIRST = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] FN_WRITE = 8'hA0;
  localparam logic [7:0] FN_EXT = 8'h80;
  localparam logic [7:0] FN_ID_IN = 8'h90;
  localparam logic [7:0] FN_ID_OUT = 8'hF0;
  localparam logic [7:0] FN_UNPROT = 8'h20;
  localparam logic [7:0] FN_ERASE = 8'h10;
endpackage

// File: rtl/sdp_cmd_decoder.sv
module sdp_cmd_decoder
  import sdp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WINDOW_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              consumed_o,
  output sdp_cmd_t          cmd_o
);
  localparam int GAP_W = $clog2(WINDOW_CYC + 1);
  localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(16'h5555);
  localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(16'h2AAA);

  seq_st_e st_q, st_d;
  logic [GAP_W-1:0] gap_q;
  logic gap_hit, at_a, is_k1, is_k2, brk;

  assign at_a    = addr_i == ADDR_A;
  assign is_k1   = at_a && data_i == KEY_FIRST;
  assign is_k2   = addr_i == ADDR_B && data_i == KEY_SECOND;
  assign gap_hit = gap_q == GAP_W'(WINDOW_CYC - 1);

  always_comb begin
    st_d       = st_q;
    consumed_o = 1'b0;
    cmd_o      = '0;
    brk        = 1'b0;
    if (load_i) begin
      case (st_q)
        ST_IDLE: brk = 1'b1;
        ST_K1: begin
          if (is_k2) begin st_d = ST_K2; consumed_o = 1'b1; end
          else brk = 1'b1;
        end
        ST_K2: begin
          if (!at_a) brk = 1'b1;
          else begin
            consumed_o = 1'b1;
            st_d = ST_IDLE;
            case (data_i)
              FN_WRITE:  cmd_o.write_unlock = 1'b1;
              FN_ID_IN:  cmd_o.id_enter = 1'b1;
              FN_ID_OUT: cmd_o.id_exit = 1'b1;
              FN_EXT:    st_d = ST_EXT;
              default: begin consumed_o = 1'b0; brk = 1'b1; end
            endcase
          end
        end
        ST_EXT: begin
          if (is_k1) begin st_d = ST_K4; consumed_o = 1'b1; end
          else brk = 1'b1;
        end
        ST_K4: begin
          if (is_k2) begin st_d = ST_K5; consumed_o = 1'b1; end
          else brk = 1'b1;
        end
        ST_K5: begin
          if (at_a && data_i == FN_UNPROT) begin
            cmd_o.unprotect = 1'b1; consumed_o = 1'b1; st_d = ST_IDLE;
          end else if (at_a && data_i == FN_ERASE) begin
            cmd_o.erase = 1'b1; consumed_o = 1'b1; st_d = ST_IDLE;
          end else brk = 1'b1;
        end
        default: brk = 1'b1;
      endcase
      // breaking byte is re-examined as the start of a fresh key
      if (brk) begin
        if (is_k1) begin st_d = ST_K1; consumed_o = 1'b1; end
        else st_d = ST_IDLE;
      end
    end else if (st_q != ST_IDLE && gap_hit) begin
      st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      gap_q <= '0;
    end else begin
      st_q <= st_d;
      if (load_i || st_q == ST_IDLE) gap_q <= '0;
      else if (!gap_hit) gap_q <= gap_q + 1'b1;
    end
  end

  AST_GAP_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && !load_i && gap_hit) |=> st_q == ST_IDLE); // R9
  AST_CONSUME_NEEDS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consumed_o |-> load_i); // R2
  AST_CMD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_o)); // R8
endmodule

// File: rtl/sdp_lockout.sv
module sdp_lockout #(
  parameter int LOCK_CYC = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(LOCK_CYC + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (start_i) cnt_q <= CNT_W'(LOCK_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = cnt_q != '0;

  AST_LOCK_COUNTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !start_i) |=> cnt_q == $past(cnt_q) - 1'b1); // R6
  AST_LOCK_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o); // R6
endmodule

// File: rtl/sdp_id_rom.sv
module sdp_id_rom #(
  parameter int ADDR_W = 16,
  parameter logic [7:0] MFR_ID = 8'hBF,
  parameter logic [7:0] DEV_ID = 8'h5D
) (
  input  logic              id_mode_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        id_data_o
);
  always_comb begin
    id_data_o = '0;
    if (id_mode_i) begin
      if (rd_addr_i == ADDR_W'(0)) id_data_o = MFR_ID;
      else if (rd_addr_i == ADDR_W'(1)) id_data_o = DEV_ID;
    end
  end
endmodule

// File: rtl/sdp_sequencer.sv
module sdp_sequencer
  import sdp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WINDOW_CYC = 16,
  parameter int LOCK_CYC = 30,
  parameter logic [7:0] MFR_ID = 8'hBF,
  parameter logic [7:0] DEV_ID = 8'h5D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_valid_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [7:0]        load_data_i,
  input  logic              page_done_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              data_load_o,
  output logic              write_ok_o,
  output logic              protected_o,
  output logic              erase_start_o,
  output logic              lockout_o,
  output logic              id_mode_o,
  output logic [7:0]        id_data_o
);
  logic load_eff, consumed, plain, violation;
  logic prot_q, unlock_q, id_q, erase_q;
  sdp_cmd_t cmd;

  assign load_eff = load_valid_i && !lockout_o;

  sdp_cmd_decoder #(.ADDR_W(ADDR_W), .WINDOW_CYC(WINDOW_CYC)) i_dec (
    .clk_i, .rst_ni,
    .load_i(load_eff), .addr_i(load_addr_i), .data_i(load_data_i),
    .consumed_o(consumed), .cmd_o(cmd)
  );

  assign plain       = load_eff && !consumed && !id_q;
  assign write_ok_o  = !prot_q || unlock_q;
  assign data_load_o = plain && write_ok_o;
  assign violation   = plain && !write_ok_o;

  sdp_lockout #(.LOCK_CYC(LOCK_CYC)) i_lock (
    .clk_i, .rst_ni, .start_i(violation), .busy_o(lockout_o)
  );

  sdp_id_rom #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) i_id (
    .id_mode_i(id_q), .rd_addr_i, .id_data_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q   <= 1'b0;
      unlock_q <= 1'b0;
      id_q     <= 1'b0;
      erase_q  <= 1'b0;
    end else begin
      erase_q <= cmd.erase;
      if (cmd.write_unlock) begin
        prot_q   <= 1'b1;
        unlock_q <= 1'b1;
      end else if (cmd.unprotect) begin
        prot_q   <= 1'b0;
        unlock_q <= 1'b0;
      end else if (page_done_i) begin
        unlock_q <= 1'b0;
      end
      if (cmd.id_enter) id_q <= 1'b1;
      else if (cmd.id_exit) id_q <= 1'b0;
    end
  end

  assign protected_o   = prot_q;
  assign id_mode_o     = id_q;
  assign erase_start_o = erase_q;

  AST_WRITE_KEY_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd.write_unlock |=> protected_o && write_ok_o); // R2
  AST_PROT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (protected_o && !cmd.unprotect) |=> protected_o); // R3
  AST_UNPROT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd.unprotect |=> !protected_o && write_ok_o); // R4
  AST_ERASE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start_o |=> !erase_start_o); // R5
  AST_NO_LOAD_IN_LOCKOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_o |-> !data_load_o); // R6
  AST_ID_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_mode_o |-> id_data_o == 8'h00); // R7
endmodule

// File: tb/test_sdp_sequencer.sv
module test_sdp_sequencer;
  localparam int W = 16;
  localparam int LOCK = 30;

  logic clk = 0, rst_n = 0;
  logic ld = 0, pdone = 0;
  logic [15:0] addr = 0, rd = 0;
  logic [7:0] dat = 0;
  logic data_load, write_ok, prot, erase, lockout, idm;
  logic [7:0] idd;

  always #5 clk = ~clk;

  sdp_sequencer #(.ADDR_W(16), .WINDOW_CYC(W), .LOCK_CYC(LOCK)) i_sdp_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .load_valid_i(ld), .load_addr_i(addr),
    .load_data_i(dat), .page_done_i(pdone), .rd_addr_i(rd),
    .data_load_o(data_load), .write_ok_o(write_ok), .protected_o(prot),
    .erase_start_o(erase), .lockout_o(lockout), .id_mode_o(idm), .id_data_o(idd)
  );

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural model state
  int m_n = 0, cyc = 0, last_cyc = -1000, lock_until = -1;
  bit m_prot = 0, m_unlock = 0, m_id = 0, m_erase = 0;

  // -1 no match, 0 partial, 1 write, 2 unprotect, 3 erase, 4 id enter, 5 id exit
  function automatic int classify(logic [15:0] a, logic [7:0] d, int n);
    logic [15:0] ea;
    ea = (n == 1 || n == 4) ? 16'h2AAA : 16'h5555;
    if (a != ea) return -1;
    case (n)
      0, 3: return (d == 8'hAA) ? 0 : -1;
      1, 4: return (d == 8'h55) ? 0 : -1;
      2: case (d)
           8'hA0: return 1;
           8'h90: return 4;
           8'hF0: return 5;
           8'h80: return 0;
           default: return -1;
         endcase
      5: return (d == 8'h20) ? 2 : (d == 8'h10) ? 3 : -1;
      default: return -1;
    endcase
  endfunction

  function automatic void eval(output bit plain, output int code, output int new_n);
    int n, c;
    n = m_n;
    if (n > 0 && cyc - last_cyc > W) n = 0;
    c = classify(addr, dat, n);
    plain = 0; code = -1; new_n = 0;
    if (c >= 0) begin
      code = c; new_n = (c == 0) ? n + 1 : 0;
    end else if (n > 0 && classify(addr, dat, 0) == 0) begin
      code = 0; new_n = 1;
    end else plain = 1;
  endfunction

  function automatic bit locked();
    return cyc <= lock_until;
  endfunction

  function automatic bit exp_load();
    bit p; int c, nn;
    if (!ld || locked()) return 0;
    eval(p, c, nn);
    return p && !m_id && (!m_prot || m_unlock);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_n = 0; cyc = 0; last_cyc = -1000; lock_until = -1;
      m_prot = 0; m_unlock = 0; m_id = 0; m_erase = 0;
    end else begin
      bit p; int c, nn;
      c = -1;
      m_erase = 0;
      if (ld && !locked()) begin
        eval(p, c, nn);
        m_n = nn; last_cyc = cyc;
        if (p && !m_id && m_prot && !m_unlock) lock_until = cyc + LOCK;
        case (c)
          1: begin m_prot = 1; m_unlock = 1; end
          2: begin m_prot = 0; m_unlock = 0; end
          3: m_erase = 1;
          4: m_id = 1;
          5: m_id = 0;
          default: ;
        endcase
      end
      if (pdone && c != 1 && c != 2) m_unlock = 0;
      cyc++;
    end
  end

  task automatic chk(bit ok, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] exp_id();
    if (!m_id) return 8'h00;
    if (rd == 16'h0000) return 8'hBF;
    if (rd == 16'h0001) return 8'h5D;
    return 8'h00;
  endfunction

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(prot == m_prot, "protected_o", prot, m_prot);
      chk(write_ok == (!m_prot || m_unlock), "write_ok_o", write_ok, !m_prot || m_unlock);
      chk(idm == m_id, "id_mode_o", idm, m_id);
      chk(lockout == locked(), "lockout_o", lockout, locked());
      chk(erase == m_erase, "erase_start_o", erase, m_erase);
      chk(data_load == exp_load(), "data_load_o", data_load, exp_load());
      chk(idd == exp_id(), "id_data_o", idd, exp_id());
    end
  end

  task automatic load(input logic [15:0] a, input logic [7:0] d);
    ld = 1; addr = a; dat = d;
    @(negedge clk);
    ld = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic key3(input logic [7:0] fn);
    load(16'h5555, 8'hAA); load(16'h2AAA, 8'h55); load(16'h5555, fn);
  endtask

  task automatic key6(input logic [7:0] fn);
    key3(8'h80);
    load(16'h5555, 8'hAA); load(16'h2AAA, 8'h55); load(16'h5555, fn);
  endtask

  task automatic page_done();
    pdone = 1; @(negedge clk); pdone = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    cur_req = "R1";
    chk(prot == 0 && write_ok == 1 && idm == 0 && lockout == 0 && erase == 0,
        "reset outputs", {prot, write_ok, idm, lockout, erase}, 5'b01000);
    load(16'h0100, 8'h12); load(16'h0101, 8'h34);
    idle(2);

    cur_req = "R2";
    key3(8'hA0);
    chk(prot == 1 && write_ok == 1, "after write key", {prot, write_ok}, 2'b11);
    load(16'h0200, 8'h01); load(16'h0201, 8'h02);
    idle(2);

    cur_req = "R3";
    page_done();
    chk(prot == 1 && write_ok == 0, "after page_done", {prot, write_ok}, 2'b10);
    idle(2);

    cur_req = "R6";
    load(16'h0300, 8'h77);
    idle(LOCK - 2);
    key3(8'hA0);                    // lands across the window end
    idle(LOCK + 2);
    load(16'h0300, 8'h77);          // new violation
    idle(LOCK - 1);
    load(16'h0301, 8'h11);          // last locked cycle
    load(16'h0302, 8'h22);          // first free cycle, new violation
    idle(LOCK + 2);

    cur_req = "R7";
    key3(8'h90);
    rd = 16'h0000; idle(1);
    chk(idd == 8'hBF, "mfr id", idd, 8'hBF);
    rd = 16'h0001; idle(1);
    chk(idd == 8'h5D, "dev id", idd, 8'h5D);
    rd = 16'h0002; idle(1);
    load(16'h0400, 8'h55);
    key3(8'hF0);
    rd = 16'h0000; idle(2);

    cur_req = "R5";
    key6(8'h10);
    idle(3);

    cur_req = "R4";
    key6(8'h20);
    chk(prot == 0 && write_ok == 1, "after unprotect", {prot, write_ok}, 2'b01);
    load(16'h0500, 8'h9A);
    idle(2);

    cur_req = "R8";
    load(16'h5555, 8'hAA); load(16'h1234, 8'h55);                    // bad addr at pos 1
    load(16'h5555, 8'hAA); load(16'h2AAA, 8'h55); load(16'h5555, 8'h33);
    load(16'h5555, 8'hAA); load(16'h5555, 8'hAA); load(16'h2AAA, 8'h55);
    load(16'h5555, 8'hA0);                                            // restart via AA
    page_done();
    key3(8'h80); load(16'h5555, 8'hAA); load(16'h2AAA, 8'h55); load(16'h5555, 8'h44);
    idle(LOCK + 2);
    key3(8'h80); load(16'h5555, 8'hAA); load(16'h2AAA, 8'h56);
    idle(LOCK + 2);
    key6(8'h20);
    idle(2);

    cur_req = "R9";
    load(16'h5555, 8'hAA); idle(W - 1); load(16'h2AAA, 8'h55);
    idle(W - 1); load(16'h5555, 8'hA0);                               // accepted
    page_done();
    key6(8'h20);
    load(16'h5555, 8'hAA); idle(W); load(16'h2AAA, 8'h55);           // stale
    load(16'h5555, 8'hA0);
    idle(W + 2);
    load(16'h0600, 8'h01);
    idle(3);
    chk(prot == 0, "gap left unprotected", prot, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule